// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block copies a block of data from one memory region to another on its own, so the processor does not have to. Software programs three registers over a 32-bit register bus: a source address, a destination address, and a count of transfer units. It then sets the run bit in the channel control word. The engine moves one unit per step through a valid/ready master port. Each step is one read of the source followed by one write of that data to the destination. After each step it advances whichever addresses are set to increment. When the count reaches zero it sets an end flag and can raise an interrupt.

A global word holds a master enable, a sticky address-error flag and a sticky NMI flag. While either flag is set, or the master enable is clear, the engine issues no new units. The address-error flag is set when the source or destination is not aligned to the unit size. The NMI flag is set by an external input. Software clears either flag by writing a 0 to it. The live address and count registers can be read at any time, so software can work out how much is left after a halt.

Master port rules:
- A request (`m_valid`) stays asserted, with address, direction, size and write data unchanged, until `m_ready` is seen high at a clock edge.
- A read is complete when `m_rvalid` returns with `m_rdata`. Only one read is ever outstanding.
- A write is complete at its handshake.

Top module: `dmac_top`

## Requirements
- R1: After reset the source, destination and count registers read 0. The control word reads 0x000000F0: unit-size code 2, both increments on, auto request on, and run, end and interrupt-enable clear. The global word reads 0.
- R2: Each unit is one read at the current source address, then one write of the returned data to the current destination address. Addresses advance by the unit size in bytes only when their increment bit is set; otherwise they stay fixed.
- R3: The count register holds transfer units. After a complete transfer it reads 0, and an incrementing source reads start plus count shifted left by log2 of the unit size. After a halt, the count reads the units still left and the source has advanced by the units already moved.
- R4: Control bits 4:3 hold the unit-size code. Codes 0, 1 and 2 select 1, 2 and 4 bytes. Code 3 lies past the table end and behaves as code 0.
- R5: Control layout: bit 0 run, bit 1 end, bit 2 interrupt enable, bit 5 source increment, bit 6 destination increment, bit 7 auto request. The channel is busy while run is 1 and end is 0. A write to the address, count or control registers while busy is refused. The one exception is a control write with run 0 (a halt), which clears run, end and interrupt enable together.
- R6: When the count reaches 0 the end bit is set. `irq` equals end AND interrupt enable. A start with count 0 sets end with no bus traffic. A control write clears end only where the written end bit is 0.
- R7: Global word layout: bit 0 master enable, bit 1 NMI flag, bit 2 address-error flag. No unit starts while the master enable is 0 or either flag is 1. Work resumes once the flags are cleared and the master enable is set.
- R8: A unit whose source or destination is not a multiple of the unit size sets the address-error flag, drives `err_irq` high and makes no bus access. Writing 1 to a flag leaves it unchanged; writing 0 clears it.
- R9: A high level on `nmi_in` at a clock edge sets the NMI flag.
- R10: The master port holds each request stable until accepted. The count drops by one only when the write of a unit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| m_valid | output | 1 | Master request valid |
| m_ready | input | 1 | Master request accepted |
| m_write | output | 1 | 1 = write, 0 = read |
| m_addr | output | 32 | Master byte address |
| m_size | output | 2 | log2 of the unit size in bytes |
| m_wdata | output | 32 | Master write data |
| m_rvalid | input | 1 | Read data valid |
| m_rdata | input | 32 | Read data |
| irq | output | 1 | Transfer-end interrupt |
| err_irq | output | 1 | Address-error interrupt |
| nmi_in | input | 1 | External NMI request |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 24-bit count field and a three-entry size table. With these defaults, all three unit sizes and the out-of-table code 3 can be reached. Small unit counts under irregular `m_ready` back-pressure let the bench exercise each of the following:
- full completion;
- a halt in mid-transfer with a residue read back;
- a zero-length start;
- a misaligned start;
- a stall caused by the NMI flag.

The count field's full 24-bit width is not exercised.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam logic [6:0] RA_SRC = 7'h00;
  localparam logic [6:0] RA_DST = 7'h04;
  localparam logic [6:0] RA_CNT = 7'h08;
  localparam logic [6:0] RA_CTL = 7'h0C;
  localparam logic [6:0] RA_GLB = 7'h40;

  localparam int GB_EN   = 0;
  localparam int GB_NMI  = 1;
  localparam int GB_AERR = 2;

  // packed from bit 7 down to bit 0
  typedef struct packed {
    logic       auto_req;
    logic       dinc;
    logic       sinc;
    logic [1:0] sz_code;
    logic       ien;
    logic       ended;
    logic       run;
  } ctl_t;

  localparam logic [7:0] CTL_DEFAULT = 8'hF0;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RD_REQ, SQ_RD_WAIT, SQ_WR_REQ} sq_state_t;

  function automatic logic [1:0] unit_log2(input logic [1:0] code, input int entries);
    return (int'(code) < entries) ? code : 2'd0;
  endfunction
endpackage

// File: rtl/dmac_global.sv
module dmac_global
  import dmac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wbits,
  input  logic       nmi_in,
  input  logic       addr_err,
  output logic       dme,
  output logic       nmif,
  output logic       ae
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dme  <= 1'b0;
      nmif <= 1'b0;
      ae   <= 1'b0;
    end else begin
      if (wr_en) dme <= wbits[GB_EN];
      if (addr_err) ae <= 1'b1;
      else if (wr_en && !wbits[GB_AERR]) ae <= 1'b0;
      if (nmi_in) nmif <= 1'b1;
      else if (wr_en && !wbits[GB_NMI]) nmif <= 1'b0;
    end
  end

  p_ae_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ae && !(wr_en && !wbits[GB_AERR])) |=> ae);
  p_nmi_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_in |=> nmif);
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int SZ_ENTRIES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [6:0]        wr_addr,
  input  logic [31:0]       wdata,
  input  logic              step,
  input  logic              seq_idle,
  input  logic              run_ok,
  output logic [ADDR_W-1:0] sar,
  output logic [ADDR_W-1:0] dar,
  output logic [CNT_W-1:0]  cnt,
  output ctl_t              ctl,
  output logic [1:0]        log2sz,
  output logic              busy
);
  logic              lock;
  ctl_t              wctl;
  logic [ADDR_W-1:0] unit_bytes;

  assign busy       = ctl.run & ~ctl.ended;
  assign lock       = busy | ~seq_idle;
  assign wctl       = ctl_t'(wdata[7:0]);
  assign log2sz     = unit_log2(ctl.sz_code, SZ_ENTRIES);
  assign unit_bytes = ADDR_W'(1) << log2sz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar <= '0;
      dar <= '0;
      cnt <= '0;
      ctl <= ctl_t'(CTL_DEFAULT);
    end else begin
      if (step) begin
        if (ctl.sinc) sar <= sar + unit_bytes;
        if (ctl.dinc) dar <= dar + unit_bytes;
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1) && ctl.run) ctl.ended <= 1'b1;
      end
      if (busy && run_ok && seq_idle && cnt == '0) ctl.ended <= 1'b1;
      if (wr_en && !lock) begin
        case (wr_addr)
          RA_SRC: sar <= wdata[ADDR_W-1:0];
          RA_DST: dar <= wdata[ADDR_W-1:0];
          RA_CNT: cnt <= wdata[CNT_W-1:0];
          RA_CTL: begin
            ctl       <= wctl;
            ctl.ended <= ctl.ended & wctl.ended;
          end
          default: ;
        endcase
      end
      if (wr_en && lock && wr_addr == RA_CTL && !wctl.run) begin
        ctl.run   <= 1'b0;
        ctl.ended <= 1'b0;
        ctl.ien   <= 1'b0;
      end
    end
  end

  p_te_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.ended) |-> cnt == '0);
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == $past(cnt) - CNT_W'(1));
  p_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && wr_addr == RA_CTL && wctl.run) |=>
      ($stable(ctl.sz_code) && $stable(ctl.sinc) && $stable(ctl.dinc)));
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              cnt_nz,
  input  logic [ADDR_W-1:0] sar,
  input  logic [ADDR_W-1:0] dar,
  input  logic [1:0]        log2sz,
  output logic              step,
  output logic              addr_err,
  output logic              idle,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  input  logic              m_rvalid,
  input  logic [DATA_W-1:0] m_rdata
);
  sq_state_t         state;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        low_mask;
  logic              misalign;

  always_comb begin
    case (log2sz)
      2'd1:    low_mask = 2'b01;
      2'd2:    low_mask = 2'b11;
      default: low_mask = 2'b00;
    endcase
  end

  assign misalign = |((sar[1:0] | dar[1:0]) & low_mask);
  assign idle     = (state == SQ_IDLE);
  assign addr_err = idle && go && cnt_nz && misalign;
  assign m_valid  = (state == SQ_RD_REQ) || (state == SQ_WR_REQ);
  assign m_write  = (state == SQ_WR_REQ);
  assign m_addr   = m_write ? dar : sar;
  assign m_wdata  = data_q;
  assign step     = (state == SQ_WR_REQ) && m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      data_q <= '0;
    end else begin
      case (state)
        SQ_IDLE:    if (go && cnt_nz && !misalign) state <= SQ_RD_REQ;
        SQ_RD_REQ:  if (m_ready) state <= SQ_RD_WAIT;
        SQ_RD_WAIT: if (m_rvalid) begin
                      data_q <= m_rdata;
                      state  <= SQ_WR_REQ;
                    end
        SQ_WR_REQ:  if (m_ready) state <= SQ_IDLE;
        default:    state <= SQ_IDLE;
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata)));
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 24,
  parameter int SZ_ENTRIES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [6:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic [DATA_W-1:0] m_wdata,
  input  logic              m_rvalid,
  input  logic [DATA_W-1:0] m_rdata,
  output logic              irq,
  output logic              err_irq,
  input  logic              nmi_in
);
  logic [ADDR_W-1:0] sar, dar;
  logic [CNT_W-1:0]  cnt;
  ctl_t              ctl;
  logic [1:0]        log2sz;
  logic              busy, step, addr_err, seq_idle;
  logic              dme, nmif, ae, run_ok;

  assign run_ok  = dme & ~nmif & ~ae;
  assign irq     = ctl.ended & ctl.ien;
  assign err_irq = ae;
  assign m_size  = log2sz;

  dmac_global u_glb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_we && reg_addr == RA_GLB), .wbits(reg_wdata[2:0]),
    .nmi_in(nmi_in), .addr_err(addr_err),
    .dme(dme), .nmif(nmif), .ae(ae)
  );

  dmac_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SZ_ENTRIES(SZ_ENTRIES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_we), .wr_addr(reg_addr), .wdata(reg_wdata),
    .step(step), .seq_idle(seq_idle), .run_ok(run_ok),
    .sar(sar), .dar(dar), .cnt(cnt), .ctl(ctl), .log2sz(log2sz), .busy(busy)
  );

  dmac_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go(busy && run_ok), .cnt_nz(cnt != '0),
    .sar(sar), .dar(dar), .log2sz(log2sz),
    .step(step), .addr_err(addr_err), .idle(seq_idle),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rvalid(m_rvalid), .m_rdata(m_rdata)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_SRC:  reg_rdata = 32'(sar);
      RA_DST:  reg_rdata = 32'(dar);
      RA_CNT:  reg_rdata = 32'(cnt);
      RA_CTL:  reg_rdata = {24'h0, ctl};
      RA_GLB:  reg_rdata = {29'h0, ae, nmif, dme};
      default: reg_rdata = '0;
    endcase
  end

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_ok && seq_idle) |=> !m_valid);
endmodule

// File: tb/dmac_top_tb_top.sv
module dmac_top_tb_top;
  import dmac_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        m_valid, m_write, irq, err_irq;
  logic        m_ready = 1'b0;
  logic [31:0] m_addr, m_wdata;
  logic [1:0]  m_size;
  logic        m_rvalid = 1'b0;
  logic [31:0] m_rdata = '0;
  logic        nmi_in = 1'b0;

  always #4 clk = ~clk;

  dmac_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata), .m_rvalid(m_rvalid), .m_rdata(m_rdata),
    .irq(irq), .err_irq(err_irq), .nmi_in(nmi_in)
  );

  int total = 0;
  int bad = 0;
  int bus_cnt = 0;
  int wr_cnt = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] a; logic [31:0] d; } item_t;
  item_t exp_q[$];

  function automatic logic [31:0] fdat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic note(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: irregular ready, one-cycle read latency
  logic [7:0] lfsr = 8'h5B;
  always @(posedge clk) begin
    lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    m_ready <= lfsr[0] | lfsr[3];
    m_rvalid <= rst_n && m_valid && m_ready && !m_write;
    m_rdata  <= fdat(m_addr);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      bus_cnt++;
      if (m_write) begin
        wr_cnt++;
        if (exp_q.size() == 0) note(1'b0, "R2 unexpected write", m_addr, 32'h0);
        else begin
          item_t it;
          it = exp_q.pop_front();
          note(m_addr == it.a, "R2 write address", m_addr, it.a);
          note(m_wdata == it.d, "R2 write data", m_wdata, it.d);
        end
      end
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_ctl(input logic [1:0] code, input bit si, input bit di, input bit ie, input bit run);
    return {24'h0, 1'b1, di, si, code, ie, 1'b0, run};
  endfunction

  task automatic push_exp(input logic [31:0] s, input logic [31:0] d, input int n, input int l2, input bit si, input bit di);
    for (int i = 0; i < n; i++) begin
      item_t it;
      it.a = d + (di ? (i << l2) : 0);
      it.d = fdat(s + (si ? (i << l2) : 0));
      exp_q.push_back(it);
    end
  endtask

  task automatic prog(input logic [31:0] s, input logic [31:0] d, input int n, input logic [31:0] c);
    wr(RA_SRC, s); wr(RA_DST, d); wr(RA_CNT, n); wr(RA_CTL, c);
  endtask

  task automatic wait_irq(input string req);
    int k = 0;
    while (!irq && k < 3000) begin @(negedge clk); k++; end
    note(irq === 1'b1, req, {31'h0, irq}, 32'h1);
    repeat (2) @(negedge clk);
  endtask

  logic [31:0] v;
  int base, done;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(RA_SRC, v); note(v == 0, "R1 src reset", v, 0);
    rd(RA_DST, v); note(v == 0, "R1 dst reset", v, 0);
    rd(RA_CNT, v); note(v == 0, "R1 cnt reset", v, 0);
    rd(RA_CTL, v); note(v == 32'hF0, "R1 ctl reset", v, 32'hF0);
    rd(RA_GLB, v); note(v == 0, "R1 glb reset", v, 0);
    wr(RA_GLB, 32'h1);

    // A: 4-byte units, both increment
    push_exp(32'h1000, 32'h2000, 5, 2, 1, 1);
    prog(32'h1000, 32'h2000, 5, mk_ctl(2, 1, 1, 1, 1));
    wait_irq("R6 irq at end");
    rd(RA_CNT, v); note(v == 0, "R3 count zero", v, 0);
    rd(RA_SRC, v); note(v == 32'h1014, "R3 src end", v, 32'h1014);
    rd(RA_DST, v); note(v == 32'h2014, "R2 dst end", v, 32'h2014);
    rd(RA_CTL, v); note(v == 32'hF7, "R6 end bit set", v, 32'hF7);
    note(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);

    // B: 1-byte units, fixed destination
    push_exp(32'h3001, 32'h4003, 3, 0, 1, 0);
    prog(32'h3001, 32'h4003, 3, mk_ctl(0, 1, 0, 1, 1));
    wait_irq("R6 irq byte run");
    rd(RA_DST, v); note(v == 32'h4003, "R2 fixed dst", v, 32'h4003);
    rd(RA_SRC, v); note(v == 32'h3004, "R4 code0 src", v, 32'h3004);

    // code 3 behaves as code 0
    push_exp(32'h5001, 32'h5101, 2, 0, 1, 1);
    prog(32'h5001, 32'h5101, 2, mk_ctl(3, 1, 1, 1, 1));
    wait_irq("R4 irq code3");
    rd(RA_SRC, v); note(v == 32'h5003, "R4 code3 as byte", v, 32'h5003);

    // code 1: 2-byte units
    push_exp(32'h6000, 32'h6100, 2, 1, 1, 1);
    prog(32'h6000, 32'h6100, 2, mk_ctl(1, 1, 1, 1, 1));
    wait_irq("R4 irq code1");
    rd(RA_SRC, v); note(v == 32'h6004, "R4 code1 halfword", v, 32'h6004);

    // stall, refusal, halt and residue
    wr(RA_GLB, 32'h0);
    push_exp(32'h8000, 32'h9000, 6, 2, 1, 1);
    prog(32'h8000, 32'h9000, 6, mk_ctl(2, 1, 1, 1, 1));
    base = bus_cnt;
    repeat (20) @(negedge clk);
    note(bus_cnt == base, "R7 no traffic while disabled", bus_cnt, base);
    wr(RA_SRC, 32'h1234);
    rd(RA_SRC, v); note(v == 32'h8000, "R5 src write refused", v, 32'h8000);
    wr(RA_CTL, mk_ctl(0, 1, 1, 1, 1));
    rd(RA_CTL, v); note(v[4:3] == 2'd2, "R5 ctl write refused", v, 32'h2);
    base = wr_cnt;
    wr(RA_GLB, 32'h1);
    while (wr_cnt < base + 2) @(negedge clk);
    wr(RA_CTL, mk_ctl(2, 1, 1, 1, 0));
    repeat (20) @(negedge clk);
    done = wr_cnt - base;
    rd(RA_CTL, v); note(v[2:0] == 3'b000, "R5 halt clears run/end/ie", v, v & 32'hF8);
    rd(RA_CNT, v); note(v == 6 - done, "R3 residue count", v, 6 - done);
    rd(RA_SRC, v); note(v == 32'h8000 + 4 * done, "R3 residue src", v, 32'h8000 + 4 * done);
    note(irq == 1'b0, "R6 no irq after halt", irq, 0);
    exp_q.delete();

    // zero count
    base = bus_cnt;
    prog(32'h0, 32'h0, 0, mk_ctl(2, 1, 1, 1, 1));
    wait_irq("R6 zero count ends");
    note(bus_cnt == base, "R6 zero count no traffic", bus_cnt, base);

    // misaligned source
    base = bus_cnt;
    prog(32'h7002, 32'hA000, 1, mk_ctl(2, 1, 1, 1, 1));
    repeat (5) @(negedge clk);
    note(err_irq == 1'b1, "R8 err_irq", err_irq, 1);
    note(bus_cnt == base, "R8 no bus access", bus_cnt, base);
    rd(RA_GLB, v); note(v == 32'h5, "R8 ae flag", v, 32'h5);
    wr(RA_GLB, 32'h5);
    rd(RA_GLB, v); note(v == 32'h5, "R8 write 1 keeps ae", v, 32'h5);
    wr(RA_CTL, mk_ctl(2, 1, 1, 0, 0));
    wr(RA_GLB, 32'h1);
    rd(RA_GLB, v); note(v == 32'h1, "R8 write 0 clears ae", v, 32'h1);
    note(err_irq == 1'b0, "R8 err_irq cleared", err_irq, 0);

    // NMI
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk); nmi_in = 1'b0;
    rd(RA_GLB, v); note(v == 32'h3, "R9 nmi flag set", v, 32'h3);
    base = bus_cnt;
    push_exp(32'hB000, 32'hC000, 1, 2, 1, 1);
    prog(32'hB000, 32'hC000, 1, mk_ctl(2, 1, 1, 1, 1));
    repeat (20) @(negedge clk);
    note(bus_cnt == base, "R7 nmi stalls", bus_cnt, base);
    wr(RA_GLB, 32'h1);
    wait_irq("R7 resumes after clear");
    rd(RA_SRC, v); note(v == 32'hB004, "R7 resumed src", v, 32'hB004);
    note(exp_q.size() == 0, "R2 resumed write seen", exp_q.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      note(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule